// File: doc/BRIEF.md
# Configuration Access Router

This block sits behind a host-side configuration data port and steers each configuration request to one of several function register files. The functions live on two buses: a primary bus whose number is fixed at 0, and one secondary bus reached through a bridge function that occupies the first primary slot. Each request carries a 24-bit address. The bus number sits in bits 23:16, the device/function number in bits 15:8 (device in 15:11, function in 10:8) and the register byte offset in bits 7:0. A 2-bit length code selects a 1-, 2- or 4-byte access.

Function slots are filled at elaboration, the same way an automatic placer fills them. Primary function k takes devfn `PRI_DEVFN_MIN + 8*k`. Secondary function k takes devfn `SEC_DEVFN_MIN + 8*k`. When no bus or slot matches, a read returns all ones of its width and a write is lost. The secondary bus number that steers requests is captured from writes to the bridge's own registers. It resets to 0, which leaves the secondary bus unreachable until software programs it.

Requests use a valid/ready handshake. A read returns its data with a valid pulse one cycle after it is accepted. Only one request is in flight at a time.

Top module: `cfg_access_router`

## Requirements
- R1: A request selects a function when its bus field names that function's bus and its devfn field equals that function's slot. Primary slots are `PRI_DEVFN_MIN + 8*k` and secondary slots are `SEC_DEVFN_MIN + 8*k`. Data written to a selected function reads back from the same address.
- R2: Length code 0 accesses 1 byte, code 1 accesses 2 bytes, and codes 2 and 3 access 4 bytes. Byte n of the access maps to offset+n and to data bits 8n+7:8n (little-endian). Bits above the access width read as 0.
- R3: A read that matches no bus or no populated slot returns 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for 1-, 2- and 4-byte accesses.
- R4: A write that matches no bus or no populated slot changes no register in any function.
- R5: After reset, the bridge function holds 0x06 at offset 0x04, 0xA0 at 0x06, 0x10 at 0x0D, 0x81 at 0x0E and 0xA0 at 0x1E, with 0 elsewhere. Every other function resets to all zero.
- R6: The secondary bus number is loaded from wdata[7:0] on a bridge write at offset 0x19. It is loaded from wdata[15:8] on a bridge write of 2 or 4 bytes at offset 0x18.
- R7: No other write changes the secondary bus number. This includes a 1-byte write at 0x18 and a 4-byte write at 0x16, even though the 0x16 write stores a new byte at 0x19.
- R8: Bus 0 always goes to the primary bus. A non-zero bus number goes to the secondary bus only when it equals the programmed secondary bus number, so a secondary bus number of 0 makes the secondary functions unreachable.
- R9: reqReady is low while a read response is pending. An accepted read raises rspValid for exactly the next cycle. An accepted write raises no rspValid.
- R10: Out of reset, rspValid is 0 and reqReady is 1.
- R11: Bytes of an access at or beyond `REG_BYTES` read as 0 and are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Bus[23:16], devfn[15:8], offset[7:0] |
| reqLen | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| reqWdata | input | 32 | Write data, little-endian from the offset |
| rspValid | output | 1 | Read data valid, one cycle |
| rspData | output | 32 | Read data |

## Verification
The assertions assume that reqWrite, reqAddr, reqLen and reqWdata are steady whenever reqValid is high. They also assume the host never asserts reqValid during reset. The stimulus meets both conditions: it changes all request inputs together only on the falling clock edge, and it holds each request until a rising edge with reqReady high takes it. After each read, the stimulus waits out the cycle in which reqReady is low. Because of this, the one-cycle response assertion never faces a back-to-back request.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  typedef struct packed {
    logic doWrite;
    logic doRead;
  } cfgr_strobe_t;

  function automatic logic [2:0] lenToBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] lenToMask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Power-up contents of one register byte; the bridge carries a few fixed defaults
  function automatic logic [7:0] resetByte(input logic isBridge, input int idx);
    if (!isBridge) return 8'h00;
    case (idx)
      4:       return 8'h06;
      6:       return 8'hA0;
      13:      return 8'h10;
      14:      return 8'h81;
      30:      return 8'hA0;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgr_ctrl.sv
module cfgr_ctrl
  import cfgr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output logic         rspValid,
  output cfgr_strobe_t strobe
);

  logic accept;

  assign reqReady = !rspValid;
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobe.doWrite = accept && reqWrite;
    strobe.doRead  = accept && !reqWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strobe.doRead;
  end

  // R9: a pending response is dropped after one cycle
  a_r9_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/cfgr_datapath.sv
module cfgr_datapath
  import cfgr_pkg::*;
#(
  parameter int NUM_PRI       = 2,
  parameter int NUM_SEC       = 2,
  parameter int PRI_DEVFN_MIN = 8,
  parameter int SEC_DEVFN_MIN = 0,
  parameter int REG_BYTES     = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  cfgr_strobe_t strobe,
  input  logic [23:0]  reqAddr,
  input  logic [1:0]   reqLen,
  input  logic [31:0]  reqWdata,
  output logic [31:0]  rspData
);

  localparam int NUM_FN = NUM_PRI + NUM_SEC;
  localparam int OFF_W  = $clog2(REG_BYTES);

  logic [7:0]  busNum, devfn, offset;
  logic [7:0]  secBus;
  logic        onPri, onSec, anyHit;
  logic [2:0]  nBytes;
  logic [31:0] lenMask, hitWord, rdNext;
  logic [8:0]  byteAddr [4];
  logic [NUM_FN-1:0] fnHit;
  logic [31:0] fnRd [NUM_FN];

  assign busNum  = reqAddr[23:16];
  assign devfn   = reqAddr[15:8];
  assign offset  = reqAddr[7:0];
  assign nBytes  = lenToBytes(reqLen);
  assign lenMask = lenToMask(reqLen);

  // Primary bus wins on bus 0; secondary only when programmed non-zero
  assign onPri = (busNum == 8'd0);
  assign onSec = !onPri && (secBus != 8'd0) && (busNum == secBus);

  always_comb begin
    for (int b = 0; b < 4; b++) byteAddr[b] = {1'b0, offset} + 9'(b);
  end

  for (genvar i = 0; i < NUM_FN; i++) begin : gFn
    localparam bit         IS_BRIDGE = (i == 0);
    localparam bit         ON_PRI    = (i < NUM_PRI);
    localparam logic [7:0] SLOT      = ON_PRI ? 8'(PRI_DEVFN_MIN + 8 * i)
                                              : 8'(SEC_DEVFN_MIN + 8 * (i - NUM_PRI));
    logic [7:0]  regBytes [REG_BYTES];
    logic [31:0] rdWord;

    assign fnHit[i] = (ON_PRI ? onPri : onSec) && (devfn == SLOT);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int j = 0; j < REG_BYTES; j++) regBytes[j] <= resetByte(IS_BRIDGE, j);
      end else if (strobe.doWrite && fnHit[i]) begin
        for (int j = 0; j < REG_BYTES; j++)
          for (int b = 0; b < 4; b++)
            if ((3'(b) < nBytes) && (byteAddr[b] == 9'(j)))
              regBytes[j] <= reqWdata[8*b +: 8];
      end
    end

    always_comb begin
      rdWord = '0;
      for (int b = 0; b < 4; b++)
        if (byteAddr[b] < 9'(REG_BYTES))
          rdWord[8*b +: 8] = regBytes[byteAddr[b][OFF_W-1:0]];
    end

    assign fnRd[i] = rdWord;
  end

  always_comb begin
    hitWord = '0;
    for (int i = 0; i < NUM_FN; i++)
      if (fnHit[i]) hitWord = hitWord | fnRd[i];
  end

  assign anyHit = |fnHit;
  assign rdNext = anyHit ? (hitWord & lenMask) : lenMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rspData <= '0;
    else if (strobe.doRead) rspData <= rdNext;
  end

  // Steering register follows the bridge's own bus-number writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) secBus <= 8'd0;
    else if (strobe.doWrite && fnHit[0]) begin
      if (offset == 8'h19)                          secBus <= reqWdata[7:0];
      else if (offset == 8'h18 && reqLen != 2'd0)   secBus <= reqWdata[15:8];
    end
  end

  // R3: unmatched byte read yields 0xFF
  a_r3_miss_byte: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doRead && !anyHit && reqLen == 2'd0) |=> (rspData == 32'h0000_00FF));

  // R6: offset 0x19 write to the bridge loads the low data byte
  a_r6_secbus_load: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doWrite && fnHit[0] && offset == 8'h19) |=> (secBus == $past(reqWdata[7:0])));

  // R7: steering holds without a bridge write
  a_r7_secbus_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.doWrite && fnHit[0]) |=> $stable(secBus));

  // R8: a request never selects two functions
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fnHit));

endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfgr_pkg::*;
#(
  parameter int NUM_PRI       = 2,
  parameter int NUM_SEC       = 2,
  parameter int PRI_DEVFN_MIN = 8,
  parameter int SEC_DEVFN_MIN = 0,
  parameter int REG_BYTES     = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [23:0] reqAddr,
  input  logic [1:0]  reqLen,
  input  logic [31:0] reqWdata,
  output logic        rspValid,
  output logic [31:0] rspData
);

  cfgr_strobe_t strobe;

  cfgr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  cfgr_datapath #(
    .NUM_PRI       (NUM_PRI),
    .NUM_SEC       (NUM_SEC),
    .PRI_DEVFN_MIN (PRI_DEVFN_MIN),
    .SEC_DEVFN_MIN (SEC_DEVFN_MIN),
    .REG_BYTES     (REG_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .reqWdata (reqWdata),
    .rspData  (rspData)
  );

  // R9: accepted read answers in the next cycle
  a_r9_read_answers: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> rspValid);

  // R9: accepted write stays silent
  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> !rspValid);

  // R9: no new request taken while a response is out
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    $past(rspValid) |-> !$past(reqReady));

endmodule

// File: tb/cfg_access_router_bench.sv
module cfg_access_router_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [1:0]  reqLen = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, rspValid;
  logic [31:0] rspData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_access_router u_cfg_access_router (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData)
  );

  typedef struct packed {
    logic        wr;
    logic [23:0] addr;
    logic [1:0]  len;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 24'h00_10_20, 2'd2, 32'h1122_3344, 32'h0, 8'd1},  // R1 write fn1
    '{1'b0, 24'h00_10_20, 2'd2, 32'h0, 32'h1122_3344, 8'd1},  // R1 readback
    '{1'b0, 24'h00_10_21, 2'd0, 32'h0, 32'h0000_0033, 8'd2},  // R2 byte
    '{1'b0, 24'h00_10_22, 2'd1, 32'h0, 32'h0000_1122, 8'd2},  // R2 half
    '{1'b0, 24'h00_10_20, 2'd3, 32'h0, 32'h1122_3344, 8'd2},  // R2 code 3
    '{1'b0, 24'h00_18_00, 2'd2, 32'h0, 32'hFFFF_FFFF, 8'd3},  // R3 empty slot
    '{1'b0, 24'h00_00_00, 2'd1, 32'h0, 32'h0000_FFFF, 8'd3},  // R3 empty slot
    '{1'b0, 24'h05_00_00, 2'd0, 32'h0, 32'h0000_00FF, 8'd3},  // R3 no bus
    '{1'b0, 24'h00_08_04, 2'd0, 32'h0, 32'h0000_0006, 8'd5},  // R5
    '{1'b0, 24'h00_08_0C, 2'd2, 32'h0, 32'h0081_1000, 8'd5},  // R5
    '{1'b0, 24'h00_08_1C, 2'd2, 32'h0, 32'h00A0_0000, 8'd5},  // R5
    '{1'b0, 24'h00_08_04, 2'd2, 32'h0, 32'h00A0_0006, 8'd5},  // R5
    '{1'b0, 24'h00_10_00, 2'd2, 32'h0, 32'h0000_0000, 8'd5},  // R5 plain fn
    '{1'b1, 24'h00_18_30, 2'd2, 32'hDEAD_BEEF, 32'h0, 8'd4},  // R4 lost write
    '{1'b0, 24'h00_10_30, 2'd2, 32'h0, 32'h0000_0000, 8'd4},  // R4
    '{1'b1, 24'h00_10_3C, 2'd2, 32'hAABB_CCDD, 32'h0, 8'd11}, // R11
    '{1'b0, 24'h00_10_3E, 2'd2, 32'h0, 32'h0000_AABB, 8'd11}, // R11 past end
    '{1'b1, 24'h00_10_3E, 2'd2, 32'h1111_2222, 32'h0, 8'd11}  // R11 partial write
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [23:0] addr, input logic [1:0] len,
                        input logic [31:0] wdata, output logic [31:0] rd,
                        output logic gotRsp);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqLen = len; reqWdata = wdata;
    @(negedge clk);
    reqValid = 1'b0;
    rd = rspData;
    gotRsp = rspValid;
  endtask

  task automatic rdChk(input string tag, input logic [23:0] addr, input logic [1:0] len,
                       input logic [31:0] exp);
    logic [31:0] rd;
    logic g;
    access(1'b0, addr, len, 32'h0, rd, g);
    check(tag, rd, exp);
  endtask

  task automatic wr(input logic [23:0] addr, input logic [1:0] len, input logic [31:0] d);
    logic [31:0] rd;
    logic g;
    access(1'b1, addr, len, d, rd, g);
  endtask

  initial begin
    logic [31:0] rd;
    logic g;
    repeat (3) @(negedge clk);
    check("R10 rspValid at reset", {31'b0, rspValid}, 32'd0);
    check("R10 reqReady at reset", {31'b0, reqReady}, 32'd1);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      access(VEC[v].wr, VEC[v].addr, VEC[v].len, VEC[v].wdata, rd, g);
      if (!VEC[v].wr) check($sformatf("R%0d vector %0d", VEC[v].req, v), rd, VEC[v].exp);
    end
    rdChk("R11 partial write", 24'h00_10_3C, 2'd2, 32'h2222_CCDD);

    // R9 handshake
    access(1'b1, 24'h00_10_00, 2'd0, 32'h5A, rd, g);
    check("R9 write no response", {31'b0, g}, 32'd0);
    access(1'b0, 24'h00_10_00, 2'd0, 32'h0, rd, g);
    check("R9 read response next cycle", {31'b0, g}, 32'd1);
    check("R9 ready low during response", {31'b0, reqReady}, 32'd0);
    @(negedge clk);
    check("R9 response lasts one cycle", {31'b0, rspValid}, 32'd0);

    // R8 secondary unreachable while its number is 0
    rdChk("R8 sec bus 0 goes primary", 24'h00_00_00, 2'd0, 32'h0000_00FF);
    // R6 program via 0x19
    wr(24'h00_08_19, 2'd0, 32'h0000_0003);
    rdChk("R6 sec fn reachable", 24'h03_00_00, 2'd0, 32'h0000_0000);
    wr(24'h03_08_10, 2'd1, 32'h0000_BEEF);
    rdChk("R1 sec fn readback", 24'h03_08_10, 2'd1, 32'h0000_BEEF);
    // R6 program via 0x18 wide
    wr(24'h00_08_18, 2'd1, 32'h0000_0700);
    rdChk("R6 old number gone", 24'h03_08_10, 2'd1, 32'h0000_FFFF);
    rdChk("R6 new number via 0x18", 24'h07_08_10, 2'd1, 32'h0000_BEEF);
    // R7 non-steering writes
    wr(24'h00_08_18, 2'd0, 32'h0000_0055);
    rdChk("R7 byte at 0x18 no effect", 24'h07_08_10, 2'd1, 32'h0000_BEEF);
    wr(24'h00_08_16, 2'd2, 32'h0900_0000);
    rdChk("R7 write at 0x16 no effect", 24'h07_08_10, 2'd1, 32'h0000_BEEF);
    rdChk("R7 byte 0x19 still stored", 24'h00_08_19, 2'd0, 32'h0000_0009);
    wr(24'h00_08_18, 2'd2, 32'h0000_0400);
    rdChk("R6 4-byte write at 0x18", 24'h04_08_10, 2'd1, 32'h0000_BEEF);
    // R8 clear back to 0
    wr(24'h00_08_19, 2'd0, 32'h0000_0000);
    rdChk("R8 cleared number hides bus", 24'h04_08_10, 2'd1, 32'h0000_FFFF);
    rdChk("R8 bus 0 devfn 0 empty", 24'h00_00_00, 2'd0, 32'h0000_00FF);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule